// File: doc/BRIEF.md
# RC Oscillator Trim Search

This block works out new trim codes for a high-frequency RC oscillator from counter measurements taken against a precise reference. Each trim set has three parts: a 6-bit coarse capacitor code, a 5-bit fractional capacitor code and a 2-bit resistor code. A count of 1536 means the oscillator is exactly on frequency. A count above 1536 means the oscillator is slow.

Calibration takes two passes, each started by its own strobe. On the first strobe the block reads a measurement and the trims now in use, and computes the frequency error. It then proposes a new trim set and drives it out. The oscillator is measured again with that proposal. On the second strobe the block compares the two errors. If the proposal did at least as well, it keeps it. If not, it puts the earlier trims back and enters refine mode. In refine mode, the next first pass builds on the stored proposal instead of the trims in use.

When the fractional code leaves its usable window, the block first moves the resistor code between its two extreme values. It changes the coarse code by one step only when that swap is not available.

Top module: `rcosc_trim_search`

## Requirements
- R1: Synchronous active-low reset sets all trim outputs to 0, clears the fraction-enable, clears refine mode and clears both done pulses.
- R2: A first-pass strobe with measurement 1536 (zero error) clears refine mode, leaves all trim outputs and the fraction-enable unchanged, and pulses done_first.
- R3: A first-pass strobe with a nonzero error e = measurement − 1536 sets the fraction candidate to base fraction + (3e+2)/4 for e ≥ 0, or + (3e−2)/4 for e < 0, with division truncating toward zero. The coarse code starts from the current coarse input. The resulting trims appear at the outputs and the fraction-enable is set.
- R4: With refine mode clear, the base fraction, base resistor code and error are the current inputs and the fresh error. With refine mode set, they are the stored proposal and the error recorded by the last second pass.
- R5: A fraction candidate below 1 with resistor code 3 gives fraction max(1, f+21) and resistor 0, coarse unchanged. Otherwise it gives fraction max(1, f+11), coarse max(0, c−1) and resistor 3.
- R6: A fraction candidate above 30 with resistor code 0 gives fraction min(30, f−21) and resistor 3, coarse unchanged. Otherwise it gives fraction min(30, f−11), coarse min(63, c+1) and resistor 0.
- R7: A second-pass strobe whose error magnitude is at most that of the last first pass keeps the trim outputs and clears refine mode.
- R8: A second-pass strobe whose error magnitude is larger restores the trims captured at the last first pass and sets refine mode. Its error is stored as the base error for a later refine pass.
- R9: Each done output is a single-cycle pulse in the cycle after its strobe is sampled. The trim outputs already hold their new value in that cycle.
- R10: When both strobes are sampled in the same cycle, only the first pass is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_first_i | input | 1 | Strobe: run the proposal pass |
| start_second_i | input | 1 | Strobe: run the judging pass |
| meas_i | input | 16 | Counter measurement for the strobed pass |
| cur_coarse_i | input | 6 | Coarse capacitor code now in use |
| cur_frac_i | input | 5 | Fractional capacitor code now in use |
| cur_res_i | input | 2 | Resistor code now in use |
| trim_coarse_o | output | 6 | Coarse code to apply |
| trim_frac_o | output | 5 | Fractional code to apply |
| trim_res_o | output | 2 | Resistor code to apply |
| frac_en_o | output | 1 | Fractional trim enable |
| refine_o | output | 1 | Refine mode flag |
| done_first_o | output | 1 | Proposal pass finished |
| done_second_o | output | 1 | Judging pass finished |

## Verification
A wrong stored proposal, stored error or refine flag does not show at once. It shows only at the next first-pass strobe, when the refine base is used, or at the next second-pass strobe, when the restore writes back the captured trims. So the stimulus chains restore, refine and keep passes back to back. A behavioural model compares every output on every clock, so any difference is reported in the cycle after the strobe that exposes it.

// File: rtl/rcosc_trim_pkg.sv
// Package: shared widths, trim set type and search constants.
// Assumes the three trim fields are always handled as one set.
package rcosc_trim_pkg;
    localparam int COARSE_W = 6;
    localparam int FRAC_W   = 5;
    localparam int RES_W    = 2;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FRAC_W-1:0]   frac;
        logic [RES_W-1:0]    res;
    } trim_t;

    localparam int TARGET_COUNT = 1536;
    localparam int FRAC_LO      = 1;
    localparam int FRAC_HI      = 30;
    localparam int SWAP_OFS     = 21;
    localparam int CROSS_OFS    = 11;
endpackage

// File: rtl/rcosc_trim_err.sv
// Module: signed frequency error from a raw count.
// Assumes the measurement is an unsigned count; positive error = slow.
module rcosc_trim_err #(
    parameter int MEAS_W = 16,
    parameter int TARGET = 1536,
    localparam int ERR_W = MEAS_W + 1
) (
    input  logic [MEAS_W-1:0]       meas_i,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    zero_o
);
    localparam logic signed [ERR_W-1:0] TGT = ERR_W'(TARGET);

    logic signed [ERR_W-1:0] meas_x;

    // Extend the count and subtract the on-frequency value.
    always_comb begin
        meas_x = {1'b0, meas_i};
        err_o  = meas_x - TGT;
        zero_o = (meas_i == MEAS_W'(TARGET));
    end
endmodule

// File: rtl/rcosc_trim_propose.sv
// Module: computes the proposed trim set from a base set and an error.
// Assumes the coarse code always starts from the coarse code in use;
// on a fraction overflow the resistor swap is tried before a coarse step.
module rcosc_trim_propose
    import rcosc_trim_pkg::*;
#(
    parameter int ERR_W = 17,
    localparam int CW   = ERR_W + 4
) (
    input  trim_t                   base_i,
    input  logic [COARSE_W-1:0]     cur_coarse_i,
    input  logic signed [ERR_W-1:0] err_i,
    output trim_t                   prop_o
);
    localparam logic signed [CW-1:0] TWO    = 2;
    localparam logic signed [CW-1:0] FOUR   = 4;
    localparam logic signed [CW-1:0] LO_S   = CW'(FRAC_LO);
    localparam logic signed [CW-1:0] HI_S   = CW'(FRAC_HI);
    localparam logic signed [CW-1:0] SWAP_S = CW'(SWAP_OFS);
    localparam logic signed [CW-1:0] CRS_S  = CW'(CROSS_OFS);
    localparam logic [RES_W-1:0]     RES_TOP = '1;
    localparam logic [RES_W-1:0]     RES_BOT = '0;
    localparam logic [COARSE_W-1:0]  C_TOP   = '1;
    localparam logic [COARSE_W-1:0]  C_BOT   = '0;

    logic signed [CW-1:0] err_x, tri_e, num, step, f_raw, f_adj, f_out;
    logic [COARSE_W-1:0]  c_out;
    logic [RES_W-1:0]     r_out;

    // Scaled step with rounding away from zero, then truncating division.
    always_comb begin
        err_x = {{(CW-ERR_W){err_i[ERR_W-1]}}, err_i};
        tri_e = err_x + (err_x <<< 1);
        num   = (err_x < 0) ? (tri_e - TWO) : (tri_e + TWO);
        step  = num / FOUR;
        f_raw = $signed({{(CW-FRAC_W){1'b0}}, base_i.frac}) + step;
    end

    // Keep the fraction in its window: resistor swap first, coarse step second.
    always_comb begin
        c_out = cur_coarse_i;
        r_out = base_i.res;
        f_adj = f_raw;
        f_out = f_raw;
        if (f_raw < LO_S) begin
            if (base_i.res == RES_TOP) begin
                f_adj = f_raw + SWAP_S;
                r_out = RES_BOT;
            end else begin
                f_adj = f_raw + CRS_S;
                c_out = (cur_coarse_i == C_BOT) ? C_BOT : cur_coarse_i - 1'b1;
                r_out = RES_TOP;
            end
            f_out = (f_adj < LO_S) ? LO_S : f_adj;
        end else if (f_raw > HI_S) begin
            if (base_i.res == RES_BOT) begin
                f_adj = f_raw - SWAP_S;
                r_out = RES_TOP;
            end else begin
                f_adj = f_raw - CRS_S;
                c_out = (cur_coarse_i == C_TOP) ? C_TOP : cur_coarse_i + 1'b1;
                r_out = RES_BOT;
            end
            f_out = (f_adj > HI_S) ? HI_S : f_adj;
        end
        prop_o.coarse = c_out;
        prop_o.frac   = f_out[FRAC_W-1:0];
        prop_o.res    = r_out;
    end
endmodule

// File: rtl/rcosc_trim_judge.sv
// Module: decides whether the second measurement is at least as good.
// Assumes both errors are two's complement of the same width.
module rcosc_trim_judge #(
    parameter int ERR_W = 17
) (
    input  logic signed [ERR_W-1:0] err_old_i,
    input  logic signed [ERR_W-1:0] err_new_i,
    output logic                    keep_o
);
    logic signed [ERR_W:0] old_x, new_x, old_a, new_a;

    // Compare magnitudes; a tie keeps the new trims.
    always_comb begin
        old_x  = {err_old_i[ERR_W-1], err_old_i};
        new_x  = {err_new_i[ERR_W-1], err_new_i};
        old_a  = (old_x < 0) ? -old_x : old_x;
        new_a  = (new_x < 0) ? -new_x : new_x;
        keep_o = (new_a <= old_a);
    end
endmodule

// File: rtl/rcosc_trim_search.sv
// Module: two-pass trim search for the RC oscillator.
// Pass one proposes trims from the first measurement; pass two keeps or
// restores them and manages refine mode. Assumes strobes are single-cycle
// and that inputs are valid in the cycle their strobe is high.
module rcosc_trim_search
    import rcosc_trim_pkg::*;
#(
    parameter int MEAS_W = 16,
    localparam int ERR_W = MEAS_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_first_i,
    input  logic                start_second_i,
    input  logic [MEAS_W-1:0]   meas_i,
    input  logic [COARSE_W-1:0] cur_coarse_i,
    input  logic [FRAC_W-1:0]   cur_frac_i,
    input  logic [RES_W-1:0]    cur_res_i,
    output logic [COARSE_W-1:0] trim_coarse_o,
    output logic [FRAC_W-1:0]   trim_frac_o,
    output logic [RES_W-1:0]    trim_res_o,
    output logic                frac_en_o,
    output logic                refine_o,
    output logic                done_first_o,
    output logic                done_second_o
);
    trim_t                   cur_q, prop_q, out_q, cur_in, base, prop;
    logic signed [ERR_W-1:0] err_cur_q, err_new_q, err, base_err;
    logic                    refine_q, frac_en_q, done1_q, done2_q;
    logic                    zero, keep, run2;

    rcosc_trim_err #(.MEAS_W(MEAS_W), .TARGET(TARGET_COUNT)) u_err (
        .meas_i (meas_i),
        .err_o  (err),
        .zero_o (zero)
    );

    // Pick the starting point of the proposal from refine mode.
    always_comb begin
        cur_in.coarse = cur_coarse_i;
        cur_in.frac   = cur_frac_i;
        cur_in.res    = cur_res_i;
        base          = refine_q ? prop_q : cur_in;
        base_err      = refine_q ? err_new_q : err;
        run2          = start_second_i && !start_first_i;
    end

    rcosc_trim_propose #(.ERR_W(ERR_W)) u_propose (
        .base_i       (base),
        .cur_coarse_i (cur_coarse_i),
        .err_i        (base_err),
        .prop_o       (prop)
    );

    rcosc_trim_judge #(.ERR_W(ERR_W)) u_judge (
        .err_old_i (err_cur_q),
        .err_new_i (err),
        .keep_o    (keep)
    );

    // Pass state: captured trims, stored proposal, errors and refine flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            prop_q    <= '0;
            out_q     <= '0;
            err_cur_q <= '0;
            err_new_q <= '0;
            refine_q  <= 1'b0;
            frac_en_q <= 1'b0;
            done1_q   <= 1'b0;
            done2_q   <= 1'b0;
        end else begin
            done1_q <= start_first_i;
            done2_q <= run2;
            if (start_first_i) begin
                cur_q     <= cur_in;
                err_cur_q <= err;
                if (zero) begin
                    refine_q <= 1'b0;
                end else begin
                    prop_q    <= prop;
                    err_new_q <= base_err;
                    out_q     <= prop;
                    frac_en_q <= 1'b1;
                end
            end else if (start_second_i) begin
                err_new_q <= err;
                if (keep) begin
                    refine_q <= 1'b0;
                end else begin
                    out_q    <= cur_q;
                    refine_q <= 1'b1;
                end
            end
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        trim_coarse_o = out_q.coarse;
        trim_frac_o   = out_q.frac;
        trim_res_o    = out_q.res;
        frac_en_o     = frac_en_q;
        refine_o      = refine_q;
        done_first_o  = done1_q;
        done_second_o = done2_q;
    end

    // Zero error keeps the trims and leaves refine mode.
    assert_zero_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_first_i && zero) |=> (!refine_o && $stable(trim_coarse_o)
            && $stable(trim_frac_o) && $stable(trim_res_o)));

    // A nonzero proposal enables the fraction and lands inside the window.
    assert_frac_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_first_i && !zero) |=> (frac_en_o
            && trim_frac_o >= FRAC_W'(FRAC_LO) && trim_frac_o <= FRAC_W'(FRAC_HI)));

    // The coarse code moves by at most one step from the code in use.
    assert_coarse_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_first_i && !zero) |=> (trim_coarse_o == $past(cur_coarse_i)
            || trim_coarse_o == $past(cur_coarse_i) + 1'b1
            || trim_coarse_o == $past(cur_coarse_i) - 1'b1));

    // Refine mode is entered only by a second pass.
    assert_refine_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refine_o) |-> $past(start_second_i && !start_first_i));

    // Done pulses never overlap.
    assert_done_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_first_o, done_second_o}));

    // Simultaneous strobes run only the first pass.
    assert_first_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_first_i && start_second_i) |=> (done_first_o && !done_second_o));
endmodule

// File: tb/rcosc_trim_search_bench.sv
module rcosc_trim_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st1 = 1'b0, st2 = 1'b0;
    logic [15:0] meas = 16'd0;
    logic [5:0]  cc = '0;
    logic [4:0]  cf = '0;
    logic [1:0]  cr = '0;
    logic [5:0]  o_c;
    logic [4:0]  o_f;
    logic [1:0]  o_r;
    logic        o_en, o_ref, o_d1, o_d2;

    int  n_chk = 0, n_fail = 0;
    bit  chk_on = 1'b0;
    bit  done_flag = 1'b0;
    string tag = "R1";

    // reference model state
    int m_c = 0, m_f = 0, m_r = 0, m_en = 0, m_ref = 0, m_d1 = 0, m_d2 = 0;
    int s_cc = 0, s_cf = 0, s_cr = 0, s_ecur = 0;
    int p_c = 0, p_f = 0, p_r = 0, s_enew = 0;

    always #2.5 clk = ~clk;

    rcosc_trim_search u_rcosc_trim_search (
        .clk(clk), .rst_n(rst_n), .start_first_i(st1), .start_second_i(st2),
        .meas_i(meas), .cur_coarse_i(cc), .cur_frac_i(cf), .cur_res_i(cr),
        .trim_coarse_o(o_c), .trim_frac_o(o_f), .trim_res_o(o_r),
        .frac_en_o(o_en), .refine_o(o_ref), .done_first_o(o_d1), .done_second_o(o_d2)
    );

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int stepv(int e);
        if (e >= 0) return (3 * e + 2) / 4;
        return -((3 * (-e) + 2) / 4);
    endfunction

    // behavioural model, updated at each rising edge from the inputs
    always @(posedge clk) begin
        int e, bf, br, be, f, c, r;
        if (!rst_n) begin
            m_c = 0; m_f = 0; m_r = 0; m_en = 0; m_ref = 0; m_d1 = 0; m_d2 = 0;
            s_cc = 0; s_cf = 0; s_cr = 0; s_ecur = 0; p_c = 0; p_f = 0; p_r = 0; s_enew = 0;
        end else begin
            e = int'(meas) - 1536;
            m_d1 = st1 ? 1 : 0;
            m_d2 = (st2 && !st1) ? 1 : 0;
            if (st1) begin
                bf = m_ref ? p_f : int'(cf);
                br = m_ref ? p_r : int'(cr);
                be = m_ref ? s_enew : e;
                s_cc = cc; s_cf = cf; s_cr = cr; s_ecur = e;
                if (e == 0) begin
                    m_ref = 0;
                end else begin
                    f = bf + stepv(be); c = cc; r = br;
                    if (f < 1) begin
                        if (br == 3) begin f = (f + 21 < 1) ? 1 : f + 21; r = 0; end
                        else begin f = (f + 11 < 1) ? 1 : f + 11; c = (c > 0) ? c - 1 : 0; r = 3; end
                    end else if (f > 30) begin
                        if (br == 0) begin f = (f - 21 > 30) ? 30 : f - 21; r = 3; end
                        else begin f = (f - 11 > 30) ? 30 : f - 11; c = (c < 63) ? c + 1 : 63; r = 0; end
                    end
                    p_c = c; p_f = f; p_r = r; s_enew = be;
                    m_c = c; m_f = f; m_r = r; m_en = 1;
                end
            end else if (st2) begin
                s_enew = e;
                if (absv(e) <= absv(s_ecur)) m_ref = 0;
                else begin
                    m_c = s_cc; m_f = s_cf; m_r = s_cr; m_ref = 1;
                end
            end
        end
    end

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (chk_on && !done_flag) begin
            n_chk++;
            if (int'(o_c) != m_c || int'(o_f) != m_f || int'(o_r) != m_r || int'(o_en) != m_en
                || int'(o_ref) != m_ref || int'(o_d1) != m_d1 || int'(o_d2) != m_d2) begin
                n_fail++;
                $display("FAIL %s: actual c=%0d f=%0d r=%0d en=%0d ref=%0d d1=%0d d2=%0d expected c=%0d f=%0d r=%0d en=%0d ref=%0d d1=%0d d2=%0d",
                         tag, o_c, o_f, o_r, o_en, o_ref, o_d1, o_d2,
                         m_c, m_f, m_r, m_en, m_ref, m_d1, m_d2);
            end
        end
    end

    task automatic pass1(input string t, input int m, input int c, input int f, input int r);
        @(negedge clk);
        tag = t; meas = 16'(m); cc = 6'(c); cf = 5'(f); cr = 2'(r); st1 = 1'b1;
        @(negedge clk);
        st1 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pass2(input string t, input int m);
        @(negedge clk);
        tag = t; meas = 16'(m); st2 = 1'b1;
        @(negedge clk);
        st2 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        chk_on = 1'b1;                       // R1 reset state checked here
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pass1("R2", 1536, 7, 9, 2);          // zero error holds outputs
        pass1("R6", 1600, 20, 10, 1);        // overflow, coarse step up
        pass2("R7", 1540);                   // better: keep
        pass1("R3", 1530, 21, 30, 0);        // in-window proposal
        pass2("R8", 1560);                   // worse: restore, refine set
        pass1("R4", 1530, 21, 30, 0);        // refine base from stored proposal
        pass2("R7", 1536);                   // keep, refine cleared
        pass1("R5", 1520, 5, 2, 3);          // underflow, resistor swap
        pass1("R5", 1500, 0, 2, 1);          // underflow, coarse clamp at 0
        pass1("R6", 1580, 63, 29, 2);        // overflow, coarse clamp at 63
        pass1("R6", 1590, 10, 20, 0);        // overflow, resistor swap
        pass2("R8", 1400);                   // restore
        pass2("R8", 1700);                   // restore again from captured trims
        @(negedge clk);                      // R10 simultaneous strobes
        tag = "R10"; meas = 16'd1550; cc = 6'd30; cf = 5'd15; cr = 2'd1; st1 = 1'b1; st2 = 1'b1;
        @(negedge clk);
        st1 = 1'b0; st2 = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 400; i++) begin  // R9 mixed sequence
            @(negedge clk);
            tag = "R9";
            meas = 16'(1400 + $urandom_range(0, 300));
            cc = 6'($urandom_range(0, 63)); cf = 5'($urandom_range(0, 31)); cr = 2'($urandom_range(0, 3));
            st1 = ($urandom_range(0, 2) == 0);
            st2 = ($urandom_range(0, 2) == 0);
        end
        @(negedge clk);
        st1 = 1'b0; st2 = 1'b0;
        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule